// File: doc/BRIEF.md
# Chip Reset and Standby Sequencer

This block turns two reset sources into the single internal reset of a chip. The first source is the supply itself: while `supplyOk` is low everything is held, and each return of the supply starts a fixed power-on stretch. The second source is an active-low reset pin. The pin only has meaning once the supply is good, because a supply that is absent already holds the chip in power-on reset. Either source drops the chip into standby at once, with no clock edge needed. In standby the transceiver is disabled and its pins float, in-flight transactions are aborted, configuration state is forced to defaults, and the crystal oscillator and PLL are switched off.

Release is a sequence, not a plain synchronizer. First the oscillator is enabled. The PLL is enabled once the oscillator reports ready. Internal reset lifts only after the PLL lock input has been seen high for `lockSettle` consecutive cycles. The block runs from an always-on clock that is independent of the oscillator it controls. `oscReady` and `pllLock` are taken as already valid in that clock's domain.

Top module: `chip_reset_sequencer`

## Requirements
- R1: While `supplyOk` is low, the following hold at once, without waiting for a clock edge: `intRstN`=0, `oscEnable`=0, `pllEnable`=0 and `standby`=1.
- R2: With `extRstN` high, `oscEnable` goes high right after the (POR_STRETCH+2)-th rising clock edge that follows the rise of `supplyOk`. This is two synchronizer stages plus POR_STRETCH stretch cycles. It is low after every earlier edge.
- R3: A low on `extRstN` while the supply is good gives `intRstN`=0, `phyEnable`=0, `phyHiZ`=1, `xactAbort`=1 and `cfgClear`=1 without waiting for a clock edge. These values hold for as long as the pin is low.
- R4: While `extRstN` is low, `oscEnable`=0, `pllEnable`=0 and `standby`=1, without waiting for a clock edge.
- R5: After `extRstN` returns high, `oscEnable` stays low after the first and second rising edges and is high after the third.
- R6: `pllEnable` goes high right after the first rising edge at which `oscReady` is sampled high while `oscEnable` is high.
- R7: `intRstN` goes high right after the L-th consecutive rising edge at which `pllLock` is sampled high while `pllEnable` is high. L is `lockSettle`, with 0 treated as 1.
- R8: A low sample of `pllLock` before L consecutive highs restarts the count from zero.
- R9: An external reset pulse that begins and ends inside the power-on stretch does not move the edge given by R2. The pulse does still put the chip into standby while it lasts.
- R10: If `extRstN` is still low when the power-on stretch ends, `oscEnable` stays low until the timing of R5 after the pin is released.
- R11: Once internal reset has lifted, `intRstN`=1, `phyEnable`=1, `phyHiZ`=0, `xactAbort`=0, `cfgClear`=0, `oscEnable`=1, `pllEnable`=1 and `standby`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on sequencer clock |
| supplyOk | input | 1 | Supplies in range; low means power absent (power-on reset) |
| extRstN | input | 1 | External reset pin, active low |
| oscReady | input | 1 | Crystal oscillator has stabilised |
| pllLock | input | 1 | PLL reports lock |
| lockSettle | input | LOCK_W | Consecutive lock cycles required before release (0 acts as 1) |
| intRstN | output | 1 | Internal chip reset, active low |
| xactAbort | output | 1 | Abort all in-flight transactions |
| cfgClear | output | 1 | Force configuration registers to defaults |
| phyEnable | output | 1 | Transceiver enable |
| phyHiZ | output | 1 | Float the differential pair |
| oscEnable | output | 1 | Crystal oscillator enable |
| pllEnable | output | 1 | PLL enable |
| standby | output | 1 | Minimal-power standby indication |

## Verification
The release sequence is driven under four kinds of input pattern. The first is a clean power-up, which shows that the stretch length is exact. The second is a reset pulse inside the stretch and a reset held past its end, which shows whether the two sources are merged correctly or one overrides the other. The third is a pin assertion partway through a clock cycle, sampled before the next edge, which separates an asynchronous assert from a synchronized one. The last is a lock input that flickers, together with random settle counts (including zero) and random oscillator delays. Against a consecutive-high count kept in the bench, this pattern shows whether lock is counted as a run that restarts, or as a total.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_POR_HOLD  = 3'd0,
    ST_EXT_HOLD  = 3'd1,
    ST_OSC_START = 3'd2,
    ST_PLL_WAIT  = 3'd3,
    ST_RUN       = 3'd4
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } cntCtl_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clrN,
  output logic syncQ
);
  logic [STAGES-1:0] shiftQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) shiftQ <= '0;
        else       shiftQ <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) shiftQ <= '0;
        else       shiftQ <= {shiftQ[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign syncQ = shiftQ[STAGES-1];
endmodule

// File: rtl/rstseq_count.sv
module rstseq_count
  import rstseq_pkg::*;
#(
  parameter int POR_STRETCH = 40,
  parameter int LOCK_W      = 8,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              clrN,
  input  cntCtl_t           cntCtl,
  input  logic [LOCK_W-1:0] lockSettle,
  output logic              porDone,
  output logic              lockDone
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                cnt <= '0;
    else if (cntCtl.cntClear) cnt <= '0;
    else if (cntCtl.cntInc)   cnt <= cnt + 1'b1;
  end

  // stretch ends on the edge that completes POR_STRETCH counted cycles
  assign porDone  = (cnt == CNT_W'(POR_STRETCH - 1));
  // current sample is the (cnt+1)-th consecutive lock-high sample
  assign lockDone = ({1'b0, cnt} + (CNT_W+1)'(1)) >= (CNT_W+1)'(lockSettle);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic    clk,
  input  logic    porClrN,
  input  logic    porSyncQ,
  input  logic    extSyncQ,
  input  logic    oscReady,
  input  logic    pllLock,
  input  logic    porDone,
  input  logic    lockDone,
  output cntCtl_t cntCtl,
  output logic    inRun,
  output logic    oscOn,
  output logic    pllOn,
  output logic    standbyOn
);
  seqState_t state, nextState;
  logic      holdNow;

  always_ff @(posedge clk or negedge porClrN) begin
    if (!porClrN) state <= ST_POR_HOLD;
    else          state <= nextState;
  end

  always_comb begin
    nextState       = state;
    cntCtl.cntClear = 1'b0;
    cntCtl.cntInc   = 1'b0;
    unique case (state)
      ST_POR_HOLD: begin
        // stretch always completes; pin state only chooses the exit
        if (porSyncQ) begin
          if (porDone) begin
            nextState       = extSyncQ ? ST_OSC_START : ST_EXT_HOLD;
            cntCtl.cntClear = 1'b1;
          end else begin
            cntCtl.cntInc = 1'b1;
          end
        end
      end
      ST_EXT_HOLD: begin
        cntCtl.cntClear = 1'b1;
        if (extSyncQ) nextState = ST_OSC_START;
      end
      ST_OSC_START: begin
        cntCtl.cntClear = 1'b1;
        if (!extSyncQ)     nextState = ST_EXT_HOLD;
        else if (oscReady) nextState = ST_PLL_WAIT;
      end
      ST_PLL_WAIT: begin
        if (!extSyncQ) begin
          nextState       = ST_EXT_HOLD;
          cntCtl.cntClear = 1'b1;
        end else if (!pllLock) begin
          cntCtl.cntClear = 1'b1;
        end else if (lockDone) begin
          nextState       = ST_RUN;
          cntCtl.cntClear = 1'b1;
        end else begin
          cntCtl.cntInc = 1'b1;
        end
      end
      ST_RUN: begin
        cntCtl.cntClear = 1'b1;
        if (!extSyncQ) nextState = ST_EXT_HOLD;
      end
      default: nextState = ST_POR_HOLD;
    endcase
  end

  // either synchronizer output falls asynchronously; gate the phase here
  assign holdNow   = !porSyncQ || !extSyncQ;
  assign oscOn     = !holdNow && (state inside {ST_OSC_START, ST_PLL_WAIT, ST_RUN});
  assign pllOn     = !holdNow && (state inside {ST_PLL_WAIT, ST_RUN});
  assign inRun     = !holdNow && (state == ST_RUN);
  assign standbyOn = !oscOn;

  assert_pll_after_osc_R6: assert property (@(posedge clk) disable iff (!porClrN)
    $rose(pllOn) |-> $past(oscReady));

  assert_release_on_lock_R7: assert property (@(posedge clk) disable iff (!porClrN)
    $rose(inRun) |-> ($past(pllLock) && $past(pllOn)));

  assert_osc_after_sync_R5: assert property (@(posedge clk) disable iff (!porClrN)
    $rose(oscOn) |-> ($past(extSyncQ) && $past(porSyncQ)));
endmodule

// File: rtl/chip_reset_sequencer.sv
module chip_reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int POR_STRETCH = 40,
  parameter int LOCK_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              supplyOk,
  input  logic              extRstN,
  input  logic              oscReady,
  input  logic              pllLock,
  input  logic [LOCK_W-1:0] lockSettle,
  output logic              intRstN,
  output logic              xactAbort,
  output logic              cfgClear,
  output logic              phyEnable,
  output logic              phyHiZ,
  output logic              oscEnable,
  output logic              pllEnable,
  output logic              standby
);
  localparam int POR_W = $clog2(POR_STRETCH + 1);
  localparam int CNT_W = (POR_W > LOCK_W) ? POR_W : LOCK_W;

  logic    porSyncQ, extSyncQ, extClrN;
  logic    porDone, lockDone;
  logic    inRun, oscOn, pllOn, standbyOn;
  cntCtl_t cntCtl;

  assign extClrN = supplyOk && extRstN;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_porSync (
    .clk(clk), .clrN(supplyOk), .syncQ(porSyncQ));

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_extSync (
    .clk(clk), .clrN(extClrN), .syncQ(extSyncQ));

  rstseq_ctrl u_ctrl (
    .clk(clk), .porClrN(supplyOk), .porSyncQ(porSyncQ), .extSyncQ(extSyncQ),
    .oscReady(oscReady), .pllLock(pllLock), .porDone(porDone), .lockDone(lockDone),
    .cntCtl(cntCtl), .inRun(inRun), .oscOn(oscOn), .pllOn(pllOn), .standbyOn(standbyOn));

  rstseq_count #(.POR_STRETCH(POR_STRETCH), .LOCK_W(LOCK_W), .CNT_W(CNT_W)) u_count (
    .clk(clk), .clrN(supplyOk), .cntCtl(cntCtl), .lockSettle(lockSettle),
    .porDone(porDone), .lockDone(lockDone));

  assign intRstN   = inRun;
  assign xactAbort = !inRun;
  assign cfgClear  = !inRun;
  assign phyEnable = inRun;
  assign phyHiZ    = !inRun;
  assign oscEnable = oscOn;
  assign pllEnable = pllOn;
  assign standby   = standbyOn;

  assert_por_hold_R1: assert property (@(posedge clk) disable iff (!extRstN)
    !supplyOk |-> (!intRstN && !oscEnable && !pllEnable && standby));

  assert_pin_quiets_R3: assert property (@(posedge clk) disable iff (!supplyOk)
    !extRstN |-> (!intRstN && phyHiZ && !phyEnable && xactAbort && cfgClear));

  assert_pin_standby_R4: assert property (@(posedge clk) disable iff (!supplyOk)
    !extRstN |-> (standby && !oscEnable && !pllEnable));
endmodule

// File: tb/tb_chip_reset_sequencer.sv
module tb_chip_reset_sequencer;
  localparam int STRETCH = 40;
  localparam int LW      = 8;

  logic clk = 1'b0;
  logic supplyOk, extRstN, oscReady, pllLock;
  logic [LW-1:0] lockSettle;
  logic intRstN, xactAbort, cfgClear, phyEnable, phyHiZ, oscEnable, pllEnable, standby;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  chip_reset_sequencer #(.POR_STRETCH(STRETCH), .LOCK_W(LW), .SYNC_STAGES(2)) dut (
    .clk(clk), .supplyOk(supplyOk), .extRstN(extRstN), .oscReady(oscReady),
    .pllLock(pllLock), .lockSettle(lockSettle), .intRstN(intRstN), .xactAbort(xactAbort),
    .cfgClear(cfgClear), .phyEnable(phyEnable), .phyHiZ(phyHiZ), .oscEnable(oscEnable),
    .pllEnable(pllEnable), .standby(standby));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int effSettle(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  task automatic checkRun();
    checkEq("R11 intRstN", intRstN, 1);
    checkEq("R11 phyEnable", phyEnable, 1);
    checkEq("R11 phyHiZ", phyHiZ, 0);
    checkEq("R11 xactAbort", xactAbort, 0);
    checkEq("R11 cfgClear", cfgClear, 0);
    checkEq("R11 osc/pll", {oscEnable, pllEnable}, 2'b11);
    checkEq("R11 standby", standby, 0);
  endtask

  task automatic lockStep(input bit b, input int lm, inout int consec);
    pllLock = b;
    tick();
    consec = b ? consec + 1 : 0;
    checkEq("R8 intRstN vs consecutive lock", intRstN, (consec >= lm) ? 1 : 0);
  endtask

  // oscillator just enabled: wait, report ready, then hold lock steadily
  task automatic runOscPll(input int l, input int oscDelay);
    int lm = effSettle(l);
    lockSettle = LW'(l);
    for (int i = 0; i < oscDelay; i++) begin
      tick();
      checkEq("R6 pllEnable before ready", pllEnable, 0);
    end
    oscReady = 1'b1;
    tick();
    checkEq("R6 pllEnable after ready", pllEnable, 1);
    pllLock = 1'b1;
    for (int k = 1; k <= lm; k++) begin
      tick();
      checkEq("R7 intRstN during settle", intRstN, (k == lm) ? 1 : 0);
    end
  endtask

  task automatic extReset(input int lowCycles);
    #2;
    extRstN  = 1'b0;
    oscReady = 1'b0;
    pllLock  = 1'b0;
    #1;
    checkEq("R3 intRstN async", intRstN, 0);
    checkEq("R3 phy hiZ/enable", {phyHiZ, phyEnable}, 2'b10);
    checkEq("R3 abort/clear", {xactAbort, cfgClear}, 2'b11);
    checkEq("R4 osc/pll off", {oscEnable, pllEnable}, 2'b00);
    checkEq("R4 standby", standby, 1);
    for (int i = 0; i < lowCycles; i++) tick();
    checkEq("R3 held intRstN", intRstN, 0);
    extRstN = 1'b1;
    tick(); checkEq("R5 osc after edge 1", oscEnable, 0);
    tick(); checkEq("R5 osc after edge 2", oscEnable, 0);
    tick(); checkEq("R5 osc after edge 3", oscEnable, 1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    finishRun();
  end

  initial begin
    int seedDummy;
    int consec;
    int lr;
    supplyOk = 1'b0; extRstN = 1'b1; oscReady = 1'b0; pllLock = 1'b0;
    lockSettle = LW'(3);
    seedDummy = $urandom(32'd4711);

    repeat (3) tick();
    checkEq("R1 intRstN", intRstN, 0);
    checkEq("R1 osc/pll", {oscEnable, pllEnable}, 2'b00);
    checkEq("R1 standby", standby, 1);

    // clean power-up: exact stretch
    supplyOk = 1'b1;
    for (int k = 1; k <= STRETCH + 2; k++) begin
      tick();
      if (k == 1 || k == STRETCH + 1) checkEq("R2 osc before stretch end", oscEnable, 0);
      if (k == STRETCH + 2)           checkEq("R2 osc at stretch end", oscEnable, 1);
    end
    runOscPll(3, 2);
    checkRun();

    // supply dropped mid-cycle
    #2;
    supplyOk = 1'b0; oscReady = 1'b0; pllLock = 1'b0;
    #1;
    checkEq("R1 async intRstN", intRstN, 0);
    checkEq("R1 async osc/pll", {oscEnable, pllEnable}, 2'b00);
    checkEq("R1 async standby", standby, 1);
    tick(); tick();

    // pin pulse inside the stretch
    supplyOk = 1'b1;
    for (int k = 1; k <= STRETCH + 2; k++) begin
      tick();
      if (k == 5) extRstN = 1'b0;
      if (k == 6) checkEq("R9 standby during pulse", {standby, phyHiZ}, 2'b11);
      if (k == 8) extRstN = 1'b1;
      if (k == STRETCH + 1) checkEq("R9 osc before stretch end", oscEnable, 0);
      if (k == STRETCH + 2) checkEq("R9 osc at stretch end", oscEnable, 1);
    end
    runOscPll(1, 0);
    checkRun();

    // pin reset then a flickering lock
    extReset(4);
    lockSettle = LW'(4);
    oscReady = 1'b1;
    tick();
    checkEq("R6 pllEnable", pllEnable, 1);
    consec = 0;
    lockStep(1'b1, 4, consec);
    lockStep(1'b1, 4, consec);
    lockStep(1'b0, 4, consec);
    lockStep(1'b1, 4, consec);
    lockStep(1'b1, 4, consec);
    lockStep(1'b1, 4, consec);
    lockStep(1'b1, 4, consec);
    checkEq("R8 released after restart", intRstN, 1);

    // zero settle count acts as one
    extReset(2);
    runOscPll(0, 1);
    checkEq("R7 zero settle released", intRstN, 1);

    // pin held past the end of the stretch
    tick();
    supplyOk = 1'b0; oscReady = 1'b0; pllLock = 1'b0;
    tick(); tick();
    supplyOk = 1'b1;
    for (int k = 1; k <= STRETCH + 6; k++) begin
      tick();
      if (k == 4) extRstN = 1'b0;
      if (k >= STRETCH + 2) checkEq("R10 osc held by pin", oscEnable, 0);
    end
    extRstN = 1'b1;
    tick(); checkEq("R10 osc after edge 1", oscEnable, 0);
    tick(); checkEq("R10 osc after edge 2", oscEnable, 0);
    tick(); checkEq("R10 osc after edge 3", oscEnable, 1);
    runOscPll(2, 1);
    checkRun();

    // random settle counts, oscillator delays and lock patterns
    for (int it = 0; it < 40; it++) begin
      int lm;
      int dly;
      extReset(1 + int'($urandom % 5));
      lr = int'($urandom % 12);
      lm = effSettle(lr);
      lockSettle = LW'(lr);
      dly = int'($urandom % 4);
      for (int i = 0; i < dly; i++) begin
        tick();
        checkEq("R6 pll waits for ready", pllEnable, 0);
      end
      oscReady = 1'b1;
      tick();
      checkEq("R6 pllEnable", pllEnable, 1);
      consec = 0;
      for (int c = 0; c < 300; c++) begin
        lockStep(($urandom % 4) != 0, lm, consec);
        if (consec >= lm) break;
      end
      checkEq("R7 released", intRstN, 1);
    end

    finishRun();
  end
endmodule